// File: doc/BRIEF.md
# Half-Duplex Inter-Packet Gap Deferral Timer

This block decides when the transmit side of an Ethernet MAC may start a frame. In half-duplex operation it waits for the medium to fall quiet and then times a gap in two parts. During the first part, called the deferral window, carrier from another station sends the timer back to wait for quiet again. During the second part, carrier is ignored and the gap runs to its end. This lets a waiting station claim the medium fairly, at the cost of a possible collision. After the MAC's own frame, a separate back-to-back gap is timed instead. In full-duplex operation carrier plays no part, and only the back-to-back gap separates frames.

Every gap length is a 7-bit field in bit-time units. A parameter sets the number of clock cycles per unit. A deferral window programmed longer than the total gap is limited to the total gap. The receive side holds a separate check: a receive frame that starts too soon after the end of the previous one raises a one-cycle error pulse. The recommended field values are 64 units for the window, 96 for the total gap, 96 for the back-to-back gap and 80 for the minimum receive gap. They are provided as package constants.

Top module: `ipg_defer_timer`

## Requirements
- R1: While `rst_n` is low, `tx_permit` and `rx_ifg_err` are 0, and the timer is waiting for a quiet medium.
- R2: A transmit starts on a clock edge that samples `tx_req`=1 with `tx_permit`=1. `tx_permit` is 0 from the next cycle until a new gap completes. `tx_req` has no effect while `tx_permit` is 0, and `tx_permit` stays 1 while `tx_req` is 0.
- R3: In half duplex, `tx_permit` rises on the edge that comes `gap_len`×UNIT_CLKS edges after the first edge that samples `crs`=0 while waiting. It is counted as the 1 + `gap_len`×UNIT_CLKS-th edge, with 25 edges for `gap_len`=12 and UNIT_CLKS=2.
- R4: Carrier sampled during the first `min(win_len,gap_len)`×UNIT_CLKS cycles of a gap abandons that gap. The timer waits for `crs`=0 again and then times the whole gap afresh.
- R5: Carrier that appears after the deferral window has passed has no effect. `tx_permit` rises at the same edge as on a quiet medium and stays 1 while carrier remains.
- R6: A `win_len` larger than `gap_len` acts as `gap_len`, so carrier anywhere in the gap restarts deferral.
- R7: After the edge that samples `tx_done`=1 during the MAC's own transmit, `tx_permit` rises `b2b_len`×UNIT_CLKS edges later when no carrier is seen. `tx_done` has no effect at any other time.
- R8: In half duplex, carrier during the back-to-back gap abandons it. The timer then waits for quiet and times the full two-part gap.
- R9: With `full_duplex`=1, `crs` has no effect. The back-to-back gap is timed after reset and after each own transmit.
- R10: When `rx_dv` rises after a run of N cycles low, and N < `rx_min_gap`×UNIT_CLKS, `rx_ifg_err` is 1 for exactly the one cycle after the edge that first samples `rx_dv`=1. When N is equal to or greater than that value, it stays 0.
- R11: The first `rx_dv` rise after reset is never flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| full_duplex | input | 1 | 1 = full duplex, 0 = half duplex |
| crs | input | 1 | Carrier sense from the medium |
| tx_req | input | 1 | Transmit request |
| tx_done | input | 1 | One-cycle strobe at the end of the MAC's own frame |
| win_len | input | FW | Deferral window length in units |
| gap_len | input | FW | Total non-back-to-back gap in units |
| b2b_len | input | FW | Back-to-back gap in units |
| rx_min_gap | input | FW | Minimum receive inter-frame gap in units |
| rx_dv | input | 1 | Receive frame in progress |
| tx_permit | output | 1 | Transmission may start |
| rx_ifg_err | output | 1 | One-cycle pulse for a too-short receive gap |

## Verification
`tx_permit` comes from one state register. It changes on the edge after the deciding sample, so the gap edge counts in R3, R5, R7 and R9 count from the edge that samples the triggering input, including that edge. `rx_ifg_err` is registered once and is due right after the edge that first samples `rx_dv` high. A behavioural reference model updates on every rising edge. Both outputs are compared with it 1 ns after each edge. Directed checks count edges from the stimulus until `tx_permit` rises and compare that count with the figure computed from the field values.

// File: rtl/ipg_defer_pkg.sv
package ipg_defer_pkg;

  typedef enum logic [2:0] {
    ST_TXING    = 3'd0,
    ST_B2B      = 3'd1,
    ST_WAIT_CRS = 3'd2,
    ST_GAP      = 3'd3,
    ST_READY    = 3'd4
  } phase_e;

  // Recommended field values in bit-time units
  localparam int unsigned DEF_WIN_LEN    = 64;
  localparam int unsigned DEF_GAP_LEN    = 96;
  localparam int unsigned DEF_B2B_LEN    = 96;
  localparam int unsigned DEF_RX_MIN_GAP = 80;

endpackage

// File: rtl/ipg_gap_counter.sv
module ipg_gap_counter #(
  parameter int unsigned TW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic [TW-1:0] thr,
  output logic [TW-1:0] elapsed,
  output logic          hit
);

  // The gap is over once the cycle being counted now is the thr-th one
  function automatic logic reaches(input logic [TW-1:0] e, input logic [TW-1:0] t);
    return ({1'b0, e} + (TW+1)'(1)) >= {1'b0, t};
  endfunction

  assign hit = reaches(elapsed, thr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elapsed <= '0;
    end else if (clr) begin
      elapsed <= '0;
    end else if (en && (elapsed != {TW{1'b1}})) begin
      elapsed <= elapsed + TW'(1);
    end
  end

endmodule

// File: rtl/ipg_rx_ifg_check.sv
module ipg_rx_ifg_check #(
  parameter int unsigned TW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_dv,
  input  logic [TW-1:0] min_ticks,
  output logic          rx_ifg_err
);

  logic          dv_q;
  logic          seen_end_q;
  logic [TW-1:0] low_cnt_q;
  logic          frame_start_ev;
  logic          frame_end_ev;
  logic          short_gap_ev;

  function automatic logic too_short(input logic [TW-1:0] lows, input logic [TW-1:0] lim);
    return lows < lim;
  endfunction

  assign frame_start_ev = rx_dv && !dv_q;
  assign frame_end_ev   = !rx_dv && dv_q;
  assign short_gap_ev   = frame_start_ev && seen_end_q && too_short(low_cnt_q, min_ticks);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dv_q       <= 1'b0;
      seen_end_q <= 1'b0;
      low_cnt_q  <= '0;
      rx_ifg_err <= 1'b0;
    end else begin
      dv_q       <= rx_dv;
      rx_ifg_err <= short_gap_ev;
      if (frame_end_ev) seen_end_q <= 1'b1;
      if (rx_dv) begin
        low_cnt_q <= '0;
      end else if (low_cnt_q != {TW{1'b1}}) begin
        low_cnt_q <= low_cnt_q + TW'(1);
      end
    end
  end

  // R10
  err_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ifg_err |-> ($past(rx_dv) && !$past(rx_dv, 2)));

endmodule

// File: rtl/ipg_defer_timer.sv
module ipg_defer_timer
  import ipg_defer_pkg::*;
#(
  parameter int unsigned FW        = 7,
  parameter int unsigned UNIT_CLKS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          full_duplex,
  input  logic          crs,
  input  logic          tx_req,
  input  logic          tx_done,
  input  logic [FW-1:0] win_len,
  input  logic [FW-1:0] gap_len,
  input  logic [FW-1:0] b2b_len,
  input  logic [FW-1:0] rx_min_gap,
  input  logic          rx_dv,
  output logic          tx_permit,
  output logic          rx_ifg_err
);

  localparam int unsigned TW = FW + $clog2(UNIT_CLKS + 1);

  function automatic logic [TW-1:0] to_ticks(input logic [FW-1:0] units);
    return TW'(units) * TW'(UNIT_CLKS);
  endfunction

  function automatic logic [FW-1:0] clamp_win(input logic [FW-1:0] w, input logic [FW-1:0] g);
    return (w > g) ? g : w;
  endfunction

  logic [TW-1:0] win_ticks, gap_ticks, b2b_ticks, rxmin_ticks;
  assign win_ticks   = to_ticks(clamp_win(win_len, gap_len));
  assign gap_ticks   = to_ticks(gap_len);
  assign b2b_ticks   = to_ticks(b2b_len);
  assign rxmin_ticks = to_ticks(rx_min_gap);

  phase_e        st_q, st_d;
  logic          half;
  logic [TW-1:0] elapsed;
  logic [TW-1:0] thr_sel;
  logic          cnt_hit, cnt_clr, cnt_en;
  logic          in_win;

  // Named events
  logic tx_start_ev, win_carrier_ev, late_carrier_ev, b2b_carrier_ev;

  assign half            = !full_duplex;
  assign in_win          = elapsed < win_ticks;
  assign tx_start_ev     = (st_q == ST_READY) && tx_req;
  assign win_carrier_ev  = (st_q == ST_GAP) && half && crs && in_win;
  assign late_carrier_ev = (st_q == ST_GAP) && half && crs && !in_win;
  assign b2b_carrier_ev  = (st_q == ST_B2B) && half && crs;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_READY:    if (tx_start_ev) st_d = ST_TXING;
      ST_TXING:    if (tx_done) st_d = ST_B2B;
      ST_B2B: begin
        if (b2b_carrier_ev)  st_d = ST_WAIT_CRS;
        else if (cnt_hit)    st_d = ST_READY;
      end
      ST_WAIT_CRS: begin
        if (!half)           st_d = ST_B2B;
        else if (!crs)       st_d = ST_GAP;
      end
      ST_GAP: begin
        if (win_carrier_ev)  st_d = ST_WAIT_CRS;
        else if (cnt_hit)    st_d = ST_READY;
      end
      default:               st_d = ST_WAIT_CRS;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_WAIT_CRS;
    else        st_q <= st_d;
  end

  assign cnt_clr = (st_d != st_q);
  assign cnt_en  = (st_q == ST_GAP) || (st_q == ST_B2B);
  assign thr_sel = (st_q == ST_B2B) ? b2b_ticks : gap_ticks;

  ipg_gap_counter #(.TW(TW)) u_gap_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (cnt_clr),
    .en      (cnt_en),
    .thr     (thr_sel),
    .elapsed (elapsed),
    .hit     (cnt_hit)
  );

  ipg_rx_ifg_check #(.TW(TW)) u_rx_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_dv      (rx_dv),
    .min_ticks  (rxmin_ticks),
    .rx_ifg_err (rx_ifg_err)
  );

  assign tx_permit = (st_q == ST_READY);

  // R2
  permit_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req && tx_permit) |=> !tx_permit);

  // R3
  permit_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_permit) |-> $past(cnt_hit));

  // R4
  win_defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_carrier_ev |=> (st_q == ST_WAIT_CRS));

  // R5
  late_carrier_chk: assert property (@(posedge clk) disable iff (!rst_n)
    late_carrier_ev |=> (st_q != ST_WAIT_CRS));

  // R9
  fdx_no_defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full_duplex && (st_q == ST_B2B)) |=> (st_q != ST_WAIT_CRS));

endmodule

// File: tb/test_ipg_defer_timer.sv
module test_ipg_defer_timer;
  import ipg_defer_pkg::*;

  localparam int UC = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic full_duplex = 1'b0, crs = 1'b0, tx_req = 1'b0, tx_done = 1'b0, rx_dv = 1'b0;
  logic [6:0] win_len = 7'd8, gap_len = 7'd12, b2b_len = 7'd10, rx_min_gap = 7'd6;
  logic tx_permit, rx_ifg_err;

  int vectors = 0;
  int fails = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  ipg_defer_timer i_ipg_defer_timer (
    .clk(clk), .rst_n(rst_n), .full_duplex(full_duplex), .crs(crs),
    .tx_req(tx_req), .tx_done(tx_done), .win_len(win_len), .gap_len(gap_len),
    .b2b_len(b2b_len), .rx_min_gap(rx_min_gap), .rx_dv(rx_dv),
    .tx_permit(tx_permit), .rx_ifg_err(rx_ifg_err)
  );

  // Reference model: phase codes 0 sending, 1 after-own gap, 2 wait quiet, 3 gap, 4 ready
  int m_ph = 2, m_el = 0, m_low = 0;
  bit m_prev = 0, m_seen = 0, m_err = 0;
  int lim1, lim2, limb;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 2; m_el = 0; m_prev = 0; m_seen = 0; m_low = 0; m_err = 0;
    end else begin
      lim2 = int'(gap_len) * UC;
      lim1 = (win_len > gap_len) ? lim2 : int'(win_len) * UC;
      limb = int'(b2b_len) * UC;
      case (m_ph)
        4: if (tx_req) m_ph = 0;
        0: if (tx_done) begin m_ph = 1; m_el = 0; end
        1: if (!full_duplex && crs) m_ph = 2;
           else if (m_el + 1 >= limb) m_ph = 4;
           else m_el++;
        2: if (full_duplex) begin m_ph = 1; m_el = 0; end
           else if (!crs) begin m_ph = 3; m_el = 0; end
        3: if (!full_duplex && crs && m_el < lim1) m_ph = 2;
           else if (m_el + 1 >= lim2) m_ph = 4;
           else m_el++;
        default: m_ph = 2;
      endcase
      m_err = rx_dv && !m_prev && m_seen && (m_low < int'(rx_min_gap) * UC);
      if (!rx_dv && m_prev) m_seen = 1;
      m_low = rx_dv ? 0 : m_low + 1;
      m_prev = rx_dv;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    chk({cur_req, " permit vs model"}, int'(tx_permit), int'(m_ph == 4));
    chk({cur_req, " rx error vs model"}, int'(rx_ifg_err), int'(m_err));
  end

  task automatic count_to_permit(output int n);
    n = 0;
    do begin
      @(posedge clk); #1; n++;
      tx_done = 1'b0;
    end while (!tx_permit && n < 2000);
  endtask

  task automatic start_tx();
    @(negedge clk); tx_req = 1'b1;
    @(negedge clk); tx_req = 1'b0;
    chk("R2 permit low after start", int'(tx_permit), 0);
  endtask

  // leaves the timer waiting for quiet with crs held high
  task automatic enter_wait();
    start_tx();
    repeat (3) @(negedge clk);
    tx_done = 1'b1;
    @(negedge clk); tx_done = 1'b0; crs = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int n;
    // R1 reset state
    repeat (4) @(negedge clk);
    chk("R1 permit in reset", int'(tx_permit), 0);
    chk("R1 rx error in reset", int'(rx_ifg_err), 0);
    rst_n = 1'b1;
    cur_req = "R3";
    count_to_permit(n);
    chk("R3 edges to permit", n, 25);

    cur_req = "R2";
    repeat (5) @(negedge clk);
    chk("R2 permit held without request", int'(tx_permit), 1);
    start_tx();
    tx_req = 1'b1;
    repeat (3) @(negedge clk);
    tx_req = 1'b0;
    chk("R2 request ignored while sending", int'(tx_permit), 0);

    cur_req = "R7";
    tx_done = 1'b1;
    count_to_permit(n);
    chk("R7 edges to permit after own frame", n, 21);

    cur_req = "R8";
    enter_wait();
    repeat (5) @(negedge clk);
    chk("R8 no permit while carrier", int'(tx_permit), 0);
    crs = 1'b0;
    count_to_permit(n);
    chk("R8 full gap after carrier", n, 25);

    cur_req = "R4";
    enter_wait();
    crs = 1'b0;
    repeat (5) @(negedge clk);
    crs = 1'b1;
    @(negedge clk); crs = 1'b0;
    count_to_permit(n);
    chk("R4 gap restarted after early carrier", n, 25);

    cur_req = "R5";
    enter_wait();
    crs = 1'b0;
    repeat (20) @(negedge clk);
    crs = 1'b1;
    count_to_permit(n);
    chk("R5 late carrier ignored", n, 5);
    repeat (3) @(negedge clk);
    chk("R5 permit held under carrier", int'(tx_permit), 1);
    crs = 1'b0;

    cur_req = "R6";
    win_len = 7'd40;
    enter_wait();
    crs = 1'b0;
    repeat (20) @(negedge clk);
    crs = 1'b1;
    @(negedge clk); crs = 1'b0;
    count_to_permit(n);
    chk("R6 clamped window restarts", n, 25);
    win_len = 7'd8;

    cur_req = "R9";
    full_duplex = 1'b1;
    start_tx();
    crs = 1'b1;
    repeat (3) @(negedge clk);
    tx_done = 1'b1;
    count_to_permit(n);
    chk("R9 full duplex ignores carrier", n, 21);
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    count_to_permit(n);
    chk("R9 full duplex gap after reset", n, 21);
    @(negedge clk); crs = 1'b0; full_duplex = 1'b0;

    cur_req = "R11";
    @(negedge clk); rx_dv = 1'b1;
    @(posedge clk); #1;
    chk("R11 first frame not flagged", int'(rx_ifg_err), 0);
    cur_req = "R10";
    repeat (8) @(negedge clk);
    rx_dv = 1'b0;
    repeat (3) @(negedge clk);
    rx_dv = 1'b1;
    @(posedge clk); #1;
    chk("R10 short gap flagged", int'(rx_ifg_err), 1);
    @(posedge clk); #1;
    chk("R10 flag lasts one cycle", int'(rx_ifg_err), 0);
    repeat (5) @(negedge clk);
    rx_dv = 1'b0;
    repeat (12) @(negedge clk);
    rx_dv = 1'b1;
    @(posedge clk); #1;
    chk("R10 gap at minimum accepted", int'(rx_ifg_err), 0);
    repeat (4) @(negedge clk);
    rx_dv = 1'b0;
    repeat (11) @(negedge clk);
    rx_dv = 1'b1;
    @(posedge clk); #1;
    chk("R10 gap one short flagged", int'(rx_ifg_err), 1);
    repeat (3) @(negedge clk);
    rx_dv = 1'b0;

    cur_req = "R3";
    win_len = 7'(DEF_WIN_LEN); gap_len = 7'(DEF_GAP_LEN);
    b2b_len = 7'(DEF_B2B_LEN); rx_min_gap = 7'(DEF_RX_MIN_GAP);
    enter_wait();
    crs = 1'b0;
    count_to_permit(n);
    chk("R3 recommended gap length", n, 193);

    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule